// File: doc/BRIEF.md
# Transmit Control Register with Graceful Stop

This block holds the 32-bit transmit configuration word of an Ethernet-style transmit path and runs the small controller that decides when the frame transmitter may begin a new frame. A simple register bus writes the word and reads it back. The block drives three signals toward the transmit path:

- A frame-start permit.
- A one-clock clear pulse for the read and write pointers of the transmit data FIFO.
- A one-clock clear pulse for the read and write pointers of the transmit status FIFO.

The transmitter returns frame-start and frame-end strobes and a status-FIFO-full flag.

Software turns the transmitter on with the enable bit. It can request a graceful stop with the stop bit. The frame in progress always completes. The controller then clears both the stop bit and the enable bit itself. While the stop request is pending, further writes to the stop bit are ignored. When the status FIFO is full and overrun is not allowed, no new frame may start and the controller reports a suspended state. The state of the controller is visible on a 2-bit output. The registered status-full flag is passed on, and the overrun setting never changes it.

Top module: `tx_ctl_reg`

## Requirements
- R1: After reset, the enable, stop and overrun-allow bits are 0, `tx_permit` is 0, `tx_state` is HALT (0), both flush pulses are 0 and a readback returns 0.
- R2: A read of the register offset (0x70) returns the stop bit at bit 0, enable at bit 1 and overrun-allow at bit 2, with every other bit 0, including bits 14 and 15. The data appears on `rdata` in the cycle after the clock edge that samples `rd_en`.
- R3: A write with bit 15 set drives `flush_sts` high for exactly one clock, in the cycle following the write edge.
- R4: A write with bit 14 set drives `flush_dat` high for exactly one clock, in the cycle following the write edge.
- R5: `tx_permit` is 1 only when all of these hold: enable is 1, stop is 0, no frame is in progress, and the block is not suspended. A `frame_start` sampled with `tx_permit` high moves `tx_state` to XMIT (2) until a `frame_end` is sampled, after which the state is RUN (1).
- R6: If stop is set while a frame is in progress, enable and stop both stay 1 until `frame_end` is sampled. At that same edge both clear and `tx_state` becomes HALT.
- R7: If stop is set while no frame is in progress, enable and stop clear at the next clock edge. A `frame_start` sampled at that edge is not accepted.
- R8: While the stop bit reads 1, a write of 0 to bit 0 leaves it at 1.
- R9: With overrun-allow 0 and `sts_full` high, an enabled idle block reports SUSP (3), holds `tx_permit` low and ignores `frame_start`. With overrun-allow 1, a full status FIFO does not block a start.
- R10: `full_flag` equals `sts_full` delayed by one clock, whatever the overrun-allow bit holds.
- R11: Writes and reads at any address other than the register offset change no bit and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| frame_start | input | 1 | Transmitter begins a frame (strobe) |
| frame_end | input | 1 | Transmitter finished a frame (strobe) |
| sts_full | input | 1 | Transmit status FIFO is full |
| tx_permit | output | 1 | A new frame may start now |
| flush_dat | output | 1 | One-clock data FIFO pointer clear |
| flush_sts | output | 1 | One-clock status FIFO pointer clear |
| tx_state | output | 2 | 0 HALT, 1 RUN, 2 XMIT, 3 SUSP |
| full_flag | output | 1 | Registered status-full flag |

## Verification
Register bits, the flush pulses, `rdata` and `full_flag` change one clock edge after the write, read or input that causes them. `tx_permit` and `tx_state` follow the register state and `sts_full` within the same cycle. The bench drives every input on the falling clock edge. It samples on the next falling edge, which lies after exactly one rising edge. A second sample one cycle later confirms that each flush pulse has already dropped. For the stop cases, the bench reads back after the edge where the halt must have happened, and it also checks the cycle where a competing `frame_start` was presented.

// File: rtl/tx_ctl_pkg.sv
package tx_ctl_pkg;
  typedef enum logic [1:0] {
    TXS_HALT = 2'd0,
    TXS_RUN  = 2'd1,
    TXS_XMIT = 2'd2,
    TXS_SUSP = 2'd3
  } txs_e;

  localparam int BIT_STOP = 0;
  localparam int BIT_EN   = 1;
  localparam int BIT_OVR  = 2;
  localparam int BIT_FLD  = 14;
  localparam int BIT_FLS  = 15;
endpackage

// File: rtl/tx_ctl_regs.sv
module tx_ctl_regs
  import tx_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              halt_evt,
  output logic              en_q,
  output logic              stop_q,
  output logic              ovr_q,
  output logic              flush_dat,
  output logic              flush_sts,
  output logic [DATA_W-1:0] rdata
);
  localparam int NFL = 2;

  logic hit_wr, hit_rd;
  logic [DATA_W-1:0] image;
  logic [NFL-1:0] fl_q;

  assign hit_wr = wr_en && (addr == OFFSET);
  assign hit_rd = rd_en && (addr == OFFSET);

  // Flush commands: one pulse register per channel, never held in the image
  generate
    for (genvar g = 0; g < NFL; g++) begin : g_flush
      localparam int POS = (g == 0) ? BIT_FLD : BIT_FLS;
      always_ff @(posedge clk) begin
        if (rst) fl_q[g] <= 1'b0;
        else     fl_q[g] <= hit_wr && wdata[POS];
      end
    end
  endgenerate

  assign flush_dat = fl_q[0];
  assign flush_sts = fl_q[1];

  // Control bits; hardware halt has priority over a software write
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      stop_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (halt_evt) begin
        en_q   <= 1'b0;
        stop_q <= 1'b0;
      end else if (hit_wr) begin
        en_q <= wdata[BIT_EN];
        if (!stop_q) stop_q <= wdata[BIT_STOP];
      end
      if (hit_wr) ovr_q <= wdata[BIT_OVR];
    end
  end

  always_comb begin
    image           = '0;
    image[BIT_STOP] = stop_q;
    image[BIT_EN]   = en_q;
    image[BIT_OVR]  = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (hit_rd) rdata <= image;
    else             rdata <= '0;
  end
endmodule

// File: rtl/tx_ctl_seq.sv
module tx_ctl_seq
  import tx_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_q,
  input  logic       stop_q,
  input  logic       ovr_q,
  input  logic       frame_start,
  input  logic       frame_end,
  input  logic       sts_full,
  output logic       halt_evt,
  output logic       tx_permit,
  output logic [1:0] tx_state,
  output logic       full_flag
);
  logic busy_q;
  logic blocked;
  txs_e st;

  assign blocked   = sts_full && !ovr_q;
  assign tx_permit = en_q && !stop_q && !busy_q && !blocked;
  // Stop completes when no frame is running, or when the running one ends now
  assign halt_evt  = stop_q && (!busy_q || frame_end);

  always_ff @(posedge clk) begin
    if (rst)                          busy_q <= 1'b0;
    else if (busy_q && frame_end)     busy_q <= 1'b0;
    else if (frame_start && tx_permit) busy_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) full_flag <= 1'b0;
    else     full_flag <= sts_full;
  end

  always_comb begin
    if (busy_q)       st = TXS_XMIT;
    else if (!en_q)   st = TXS_HALT;
    else if (blocked) st = TXS_SUSP;
    else              st = TXS_RUN;
  end

  assign tx_state = st;
endmodule

// File: rtl/tx_ctl_reg.sv
module tx_ctl_reg
  import tx_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              sts_full,
  output logic              tx_permit,
  output logic              flush_dat,
  output logic              flush_sts,
  output logic [1:0]        tx_state,
  output logic              full_flag
);
  logic en_q, stop_q, ovr_q, halt_evt;

  tx_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .halt_evt(halt_evt), .en_q(en_q), .stop_q(stop_q),
    .ovr_q(ovr_q), .flush_dat(flush_dat), .flush_sts(flush_sts),
    .rdata(rdata)
  );

  tx_ctl_seq u_seq (
    .clk(clk), .rst(rst), .en_q(en_q), .stop_q(stop_q), .ovr_q(ovr_q),
    .frame_start(frame_start), .frame_end(frame_end), .sts_full(sts_full),
    .halt_evt(halt_evt), .tx_permit(tx_permit), .tx_state(tx_state),
    .full_flag(full_flag)
  );
endmodule

// File: rtl/tx_ctl_reg_chk.sv
module tx_ctl_reg_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h70
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              frame_start,
  input logic              frame_end,
  input logic              sts_full,
  input logic              tx_permit,
  input logic              flush_dat,
  input logic              flush_sts,
  input logic [1:0]        tx_state,
  input logic              full_flag,
  input logic              en_q,
  input logic              stop_q,
  input logic              ovr_q
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:3] == '0);

  a_r3_flush_sts_cause: assert property (@(posedge clk) disable iff (rst)
    flush_sts |-> $past(wr_en && addr == OFFSET && wdata[15]));

  a_r4_flush_dat_cause: assert property (@(posedge clk) disable iff (rst)
    flush_dat |-> $past(wr_en && addr == OFFSET && wdata[14]));

  a_r5_start_enters_xmit: assert property (@(posedge clk) disable iff (rst)
    (frame_start && tx_permit) |=> (tx_state == 2'd2));

  a_r6_halt_clears_en: assert property (@(posedge clk) disable iff (rst)
    ($past(stop_q) && !stop_q) |-> !en_q);

  a_r6_stop_waits_frame: assert property (@(posedge clk) disable iff (rst)
    ($past(stop_q) && !stop_q) |-> ($past(tx_state != 2'd2) || $past(frame_end)));

  a_r7_stop_blocks_permit: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> !tx_permit);

  a_r9_suspend_blocks: assert property (@(posedge clk) disable iff (rst)
    (sts_full && !ovr_q) |-> !tx_permit);

  a_r10_full_follows: assert property (@(posedge clk) disable iff (rst)
    full_flag == $past(sts_full));
endmodule

bind tx_ctl_reg tx_ctl_reg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .frame_start(frame_start), .frame_end(frame_end),
  .sts_full(sts_full), .tx_permit(tx_permit), .flush_dat(flush_dat),
  .flush_sts(flush_sts), .tx_state(tx_state), .full_flag(full_flag),
  .en_q(en_q), .stop_q(stop_q), .ovr_q(ovr_q)
);

// File: tb/tx_ctl_reg_tb.sv
module tx_ctl_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        frame_start = 1'b0, frame_end = 1'b0, sts_full = 1'b0;
  logic        tx_permit, flush_dat, flush_sts, full_flag;
  logic [1:0]  tx_state;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  localparam logic [7:0] REG = 8'h70;

  always #5 clk = ~clk;

  tx_ctl_reg u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .frame_start(frame_start),
    .frame_end(frame_end), .sts_full(sts_full), .tx_permit(tx_permit),
    .flush_dat(flush_dat), .flush_sts(flush_sts), .tx_state(tx_state),
    .full_flag(full_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_start();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 permit", tx_permit, 0);
    chk("R1 state", tx_state, 0);
    chk("R1 flush", {flush_dat, flush_sts}, 0);
    rd(REG, v);
    chk("R1 readback", v, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(REG, 32'hFFFF_FFFE);
    rd(REG, v);
    chk("R2 layout all-ones write", v, 32'h6);
    wr(REG, 32'h0000_0004);
    rd(REG, v);
    chk("R2 overrun bit only", v, 32'h4);
    wr(REG, 32'h0);
  endtask

  task automatic t_flush();
    wr(REG, 32'h0000_8000);
    chk("R3 flush_sts high", flush_sts, 1);
    chk("R3 flush_dat quiet", flush_dat, 0);
    @(negedge clk);
    chk("R3 flush_sts one clock", flush_sts, 0);
    wr(REG, 32'h0000_4000);
    chk("R4 flush_dat high", flush_dat, 1);
    chk("R4 flush_sts quiet", flush_sts, 0);
    @(negedge clk);
    chk("R4 flush_dat one clock", flush_dat, 0);
  endtask

  task automatic t_permit();
    wr(REG, 32'h2);
    chk("R5 permit when enabled", tx_permit, 1);
    chk("R5 state RUN", tx_state, 1);
    pulse_start();
    chk("R5 state XMIT", tx_state, 2);
    chk("R5 no permit mid-frame", tx_permit, 0);
    pulse_end();
    chk("R5 back to RUN", tx_state, 1);
    chk("R5 permit after frame", tx_permit, 1);
  endtask

  task automatic t_stop_mid();
    logic [31:0] v;
    pulse_start();
    wr(REG, 32'h3);
    rd(REG, v);
    chk("R6 stop pending keeps en", v, 32'h3);
    chk("R6 still XMIT", tx_state, 2);
    wr(REG, 32'h2);
    rd(REG, v);
    chk("R8 stop write ignored", v, 32'h3);
    pulse_end();
    chk("R6 HALT at frame end", tx_state, 0);
    rd(REG, v);
    chk("R6 en and stop cleared", v, 32'h0);
  endtask

  task automatic t_stop_idle();
    logic [31:0] v;
    wr(REG, 32'h2);
    @(negedge clk);
    wr_en = 1'b1; addr = REG; wdata = 32'h3;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; frame_start = 1'b1;
    chk("R7 permit low with stop", tx_permit, 0);
    @(negedge clk);
    frame_start = 1'b0;
    chk("R7 start blocked, HALT", tx_state, 0);
    rd(REG, v);
    chk("R7 halted next clock", v, 32'h0);
  endtask

  task automatic t_suspend();
    wr(REG, 32'h2);
    @(negedge clk); sts_full = 1'b1;
    @(negedge clk);
    chk("R9 state SUSP", tx_state, 3);
    chk("R9 permit low", tx_permit, 0);
    chk("R10 flag follows full", full_flag, 1);
    pulse_start();
    chk("R9 start ignored", tx_state, 3);
    wr(REG, 32'h6);
    chk("R9 overrun allows", tx_permit, 1);
    chk("R9 state RUN", tx_state, 1);
    chk("R10 flag unaffected by overrun", full_flag, 1);
    @(negedge clk); sts_full = 1'b0;
    @(negedge clk);
    chk("R10 flag drops", full_flag, 0);
    wr(REG, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(8'h74, 32'h2);
    rd(REG, v);
    chk("R11 other address write ignored", v, 32'h0);
    chk("R11 permit unchanged", tx_permit, 0);
    wr(REG, 32'h4);
    rd(8'h74, v);
    chk("R11 other address reads zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_flush();
    t_permit();
    t_stop_mid();
    t_stop_idle();
    t_suspend();
    t_addr();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule